// File: doc/BRIEF.md
# Translation Cache with Hardware Page-Table Refill

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It keeps a small, fully associative set of recent translations. Each slot holds a virtual page number tag and the physical page number it maps to. A lookup that hits is answered from the slots with no memory traffic. A lookup that misses starts an internal walker. The walker reads one page table entry from a single-level table in memory through a request/response port. If the entry is usable, the walker installs it and repeats the lookup. If it is not, the walker reports a page fault. Software never takes part in a refill.

The table base is a physical address. It is captured into a register when a request is accepted, so the walker's own reads need no translation. While a walk is in progress the request port is closed through its ready output. A flush input drops every cached translation in one cycle.

The walker is a four-state machine:
- IDLE: lookups are accepted here.
  - IDLE to FETCH when an accepted lookup misses.
  - A lookup that hits answers and stays in IDLE.
- FETCH: presents the memory read.
  - FETCH to AWAIT once memory takes the read.
- AWAIT: waits for the table entry.
  - AWAIT to RETRY when the returned entry is valid.
  - AWAIT to IDLE with a fault when the entry is invalid.
- RETRY: repeats the lookup.
  - RETRY to IDLE when the lookup now hits.
  - RETRY to FETCH when it still misses, for example after a flush that coincided with the install.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is empty, `req_ready_o` is 1, and `resp_valid_o` and `mem_req_valid_o` are 0.
- R2: An accepted lookup that hits raises `resp_valid_o` in the next cycle. It returns `resp_paddr_o` = {cached PPN, virtual address bits [11:0]} with `resp_fault_o` = 0 and issues no memory read.
- R3: On a miss the walker reads address root + VPN×4, where VPN is virtual address bits [31:12] and root is the table base captured when the lookup was accepted. The request and its address stay steady until `mem_req_ready_i` is seen.
- R4: Table entry format: bits [31:12] hold the PPN and bit 0 is the valid flag. A valid entry is installed, and the stalled lookup is answered as a hit. Its `resp_valid_o` rises two cycles after the cycle in which `mem_resp_valid_i` was high.
- R5: An entry with bit 0 clear is not installed. `resp_valid_o` and `resp_fault_o` rise together one cycle after the cycle of `mem_resp_valid_i`. Repeating the same lookup walks again.
- R6: `req_ready_o` stays 0 from the cycle after a missing lookup is accepted until the walker is back in IDLE. While `mem_req_valid_o` is 1, `req_ready_o` is 0.
- R7: An install uses the lowest-numbered empty slot while any slot is empty.
- R8: When every slot is full, the victim is taken from a round-robin pointer. The pointer starts at slot 0 after reset, moves up by one after each such use, and wraps from the last slot to 0. A flush does not move it.
- R9: While `flush_i` is 1, `req_ready_o` is 0. One cycle later every slot is empty, so each later lookup walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all cached translations |
| pt_root_i | input | 32 | Physical base address of the page table |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Lookup can be accepted this cycle |
| resp_valid_o | output | 1 | Translation result valid (one cycle) |
| resp_paddr_o | output | 32 | Translated physical address |
| resp_fault_o | output | 1 | Page fault: the table entry was invalid |
| mem_req_valid_o | output | 1 | Table entry read request |
| mem_req_addr_o | output | 32 | Physical address of the table entry |
| mem_req_ready_i | input | 1 | Memory takes the read this cycle |
| mem_resp_valid_i | input | 1 | Table entry returned |
| mem_resp_data_i | input | 32 | Returned table entry |

## Verification
A hit is due in the first cycle after the accepting edge, so the bench samples at the falling edge right after acceptance. A refilled answer is due two cycles after the cycle in which the entry was returned, and a fault is due one cycle after it. The bench's memory model records the cycle in which it returned the entry, and each answer's arrival cycle is compared with that record. Hit or miss is decided by a reference model of the slots and the replacement pointer. The bench confirms that decision by counting the walker's memory reads across each lookup.

// File: rtl/xc_pkg.sv
package xc_pkg;

    // Walker states
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_FETCH = 2'd1,
        WS_AWAIT = 2'd2,
        WS_RETRY = 2'd3
    } walk_state_e;

    // Bit of a table entry that marks it usable
    localparam int PTE_VALID_BIT = 0;

endpackage

// File: rtl/xc_tag_store.sv
module xc_tag_store #(
    parameter int NUM_ENTRIES = 16,
    parameter int VPN_W       = 20,
    parameter int PPN_W       = 20,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic [VPN_W-1:0]       lk_vpn_i,
    output logic                   lk_hit_o,
    output logic [PPN_W-1:0]       lk_ppn_o,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  logic [VPN_W-1:0]       wr_vpn_i,
    input  logic [PPN_W-1:0]       wr_ppn_i,
    output logic [NUM_ENTRIES-1:0] valid_vec_o
);

    logic [NUM_ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]       tag_q [NUM_ENTRIES];
    logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;

    // Flush has priority over a same-cycle install
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tag_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (flush_i) begin
                    valid_q[i] <= 1'b0;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= wr_vpn_i;
                    ppn_q[i]   <= wr_ppn_i;
                end
            end
        end
    end

    // Parallel compare across all slots
    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn_i);
        end
    endgenerate

    always_comb begin
        lk_ppn_o = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) lk_ppn_o = lk_ppn_o | ppn_q[i];
        end
    end

    assign lk_hit_o    = |match;
    assign valid_vec_o = valid_q;

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));

    // R7
    install_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !flush_i) |=> valid_q[$past(wr_idx_i)]);

endmodule

// File: rtl/xc_victim_sel.sv
module xc_victim_sel #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] valid_vec_i,
    input  logic                   use_i,
    output logic [IDX_W-1:0]       victim_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    // Lowest empty slot: scan from the top so the lowest wins
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec_i[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_o = any_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (use_i && !any_free) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

    // R7
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && !(&valid_vec_i)) |-> !valid_vec_i[victim_o]);

endmodule

// File: rtl/xc_walk_ctrl.sv
module xc_walk_ctrl
    import xc_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VA_W-1:0]  pt_root_i,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    output logic             req_ready_o,
    output logic [VPN_W-1:0] lk_vpn_o,
    input  logic             lk_hit_i,
    input  logic [VPN_W-1:0] lk_ppn_i,
    output logic             inst_en_o,
    output logic [VPN_W-1:0] inst_vpn_o,
    output logic [VPN_W-1:0] inst_ppn_o,
    output logic             mem_req_valid_o,
    output logic [VA_W-1:0]  mem_req_addr_o,
    input  logic             mem_req_ready_i,
    input  logic             mem_resp_valid_i,
    input  logic [VA_W-1:0]  mem_resp_data_i,
    output logic             resp_valid_o,
    output logic [VA_W-1:0]  resp_paddr_o,
    output logic             resp_fault_o
);

    walk_state_e state_q, state_d;

    logic [VA_W-1:0] vaddr_q;
    logic [VA_W-1:0] root_q;
    logic            accept;
    logic            pte_ok;
    logic            resp_valid_q, resp_fault_q;
    logic [VA_W-1:0] resp_paddr_q;
    logic            unused_pte_bits;

    assign pte_ok          = mem_resp_data_i[PTE_VALID_BIT];
    assign unused_pte_bits = ^mem_resp_data_i[PAGE_BITS-1:1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d         = state_q;
        req_ready_o     = 1'b0;
        mem_req_valid_o = 1'b0;
        inst_en_o       = 1'b0;
        lk_vpn_o        = vaddr_q[VA_W-1:PAGE_BITS];
        accept          = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                req_ready_o = !flush_i;
                lk_vpn_o    = req_vaddr_i[VA_W-1:PAGE_BITS];
                accept      = req_valid_i && !flush_i;
                if (accept && !lk_hit_i) state_d = WS_FETCH;
            end
            WS_FETCH: begin
                mem_req_valid_o = 1'b1;
                if (mem_req_ready_i) state_d = WS_AWAIT;
            end
            WS_AWAIT: begin
                if (mem_resp_valid_i) begin
                    inst_en_o = pte_ok;
                    state_d   = pte_ok ? WS_RETRY : WS_IDLE;
                end
            end
            WS_RETRY: begin
                state_d = lk_hit_i ? WS_IDLE : WS_FETCH;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    assign inst_vpn_o     = vaddr_q[VA_W-1:PAGE_BITS];
    assign inst_ppn_o     = mem_resp_data_i[VA_W-1:PAGE_BITS];
    assign mem_req_addr_o = root_q + {{(PAGE_BITS-2){1'b0}}, vaddr_q[VA_W-1:PAGE_BITS], 2'b00};

    // Request capture and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q      <= '0;
            root_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_fault_q <= 1'b0;
            resp_paddr_q <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            resp_fault_q <= 1'b0;
            if (accept) begin
                vaddr_q <= req_vaddr_i;
                root_q  <= pt_root_i;
                if (lk_hit_i) begin
                    resp_valid_q <= 1'b1;
                    resp_paddr_q <= {lk_ppn_i, req_vaddr_i[PAGE_BITS-1:0]};
                end
            end
            if (state_q == WS_AWAIT && mem_resp_valid_i && !pte_ok) begin
                resp_valid_q <= 1'b1;
                resp_fault_q <= 1'b1;
                resp_paddr_q <= '0;
            end
            if (state_q == WS_RETRY && lk_hit_i) begin
                resp_valid_q <= 1'b1;
                resp_paddr_q <= {lk_ppn_i, vaddr_q[PAGE_BITS-1:0]};
            end
        end
    end

    assign resp_valid_o = resp_valid_q;
    assign resp_fault_o = resp_fault_q;
    assign resp_paddr_o = resp_paddr_q;

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R4
    retry_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_AWAIT && mem_resp_valid_i && pte_ok && !flush_i) |=> lk_hit_i);

    // R5
    fault_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_AWAIT && mem_resp_valid_i && !pte_ok) |=> (resp_valid_o && resp_fault_o));

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !req_ready_o);

    // R5
    fault_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault_o |-> resp_valid_o);

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int NUM_ENTRIES = 16,
    parameter int VA_W        = 32,
    parameter int PAGE_BITS   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic [VA_W-1:0] pt_root_i,
    input  logic            req_valid_i,
    input  logic [VA_W-1:0] req_vaddr_i,
    output logic            req_ready_o,
    output logic            resp_valid_o,
    output logic [VA_W-1:0] resp_paddr_o,
    output logic            resp_fault_o,
    output logic            mem_req_valid_o,
    output logic [VA_W-1:0] mem_req_addr_o,
    input  logic            mem_req_ready_i,
    input  logic            mem_resp_valid_i,
    input  logic [VA_W-1:0] mem_resp_data_i
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [VPN_W-1:0]       lk_vpn, lk_ppn, inst_vpn, inst_ppn;
    logic                   lk_hit, inst_en;
    logic [IDX_W-1:0]       victim;
    logic [NUM_ENTRIES-1:0] valid_vec;

    xc_walk_ctrl #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_walk (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush_i          (flush_i),
        .pt_root_i        (pt_root_i),
        .req_valid_i      (req_valid_i),
        .req_vaddr_i      (req_vaddr_i),
        .req_ready_o      (req_ready_o),
        .lk_vpn_o         (lk_vpn),
        .lk_hit_i         (lk_hit),
        .lk_ppn_i         (lk_ppn),
        .inst_en_o        (inst_en),
        .inst_vpn_o       (inst_vpn),
        .inst_ppn_o       (inst_ppn),
        .mem_req_valid_o  (mem_req_valid_o),
        .mem_req_addr_o   (mem_req_addr_o),
        .mem_req_ready_i  (mem_req_ready_i),
        .mem_resp_valid_i (mem_resp_valid_i),
        .mem_resp_data_i  (mem_resp_data_i),
        .resp_valid_o     (resp_valid_o),
        .resp_paddr_o     (resp_paddr_o),
        .resp_fault_o     (resp_fault_o)
    );

    xc_tag_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .VPN_W       (VPN_W),
        .PPN_W       (VPN_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .lk_vpn_i    (lk_vpn),
        .lk_hit_o    (lk_hit),
        .lk_ppn_o    (lk_ppn),
        .wr_en_i     (inst_en),
        .wr_idx_i    (victim),
        .wr_vpn_i    (inst_vpn),
        .wr_ppn_i    (inst_ppn),
        .valid_vec_o (valid_vec)
    );

    xc_victim_sel #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_vec_i (valid_vec),
        .use_i       (inst_en && !flush_i),
        .victim_o    (victim)
    );

endmodule

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [31:0] pt_root_i = 32'h0008_0000;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_vaddr_i = '0;
    logic        req_ready_o, resp_valid_o, resp_fault_o, mem_req_valid_o;
    logic [31:0] resp_paddr_o, mem_req_addr_o;
    logic        mem_req_ready_i = 1'b0;
    logic        mem_resp_valid_i = 1'b0;
    logic [31:0] mem_resp_data_i = '0;

    xlate_cache u_dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int tests = 0, fails = 0, cyc = 0, walks = 0, resp_cyc = 0;
    bit finished = 0;
    logic [19:0] cur_vpn;
    logic [31:0] cur_root;

    // Reference slots
    bit          m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    int          m_ptr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit pte_ok(logic [19:0] v);
        return (v % 7) != 3;
    endfunction
    function automatic logic [19:0] pte_ppn(logic [19:0] v);
        return 20'(v * 13 + 20'h3C1A5);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: holds off ready a few cycles, then returns the entry
    initial begin
        forever begin
            @(negedge clk);
            mem_resp_valid_i = 1'b0;
            mem_req_ready_i  = 1'b0;
            if (mem_req_valid_o) begin
                logic [31:0] first_addr;
                first_addr = mem_req_addr_o;
                repeat ($urandom % 3) @(negedge clk);
                chk(mem_req_valid_o && mem_req_addr_o == first_addr, "R3", "request held",
                    mem_req_addr_o, first_addr);
                chk(mem_req_addr_o == cur_root + {10'd0, cur_vpn, 2'b00}, "R3", "entry address",
                    mem_req_addr_o, cur_root + {10'd0, cur_vpn, 2'b00});
                mem_req_ready_i = 1'b1;
                @(negedge clk);
                mem_req_ready_i = 1'b0;
                repeat (1 + $urandom % 2) @(negedge clk);
                mem_resp_data_i  = {pte_ppn(cur_vpn), 11'h2AA, pte_ok(cur_vpn)};
                mem_resp_valid_i = 1'b1;
                resp_cyc = cyc;
                walks++;
            end
        end
    end

    function automatic int model_find(logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic model_install(logic [19:0] v);
        int slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_valid[slot] = 1;
        m_vpn[slot]   = v;
        m_ppn[slot]   = pte_ppn(v);
    endtask

    task automatic lookup(logic [31:0] va, string req);
        int idx, w0, n;
        logic [31:0] exp_pa;
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        cur_vpn  = va[31:12];
        cur_root = pt_root_i;
        idx = model_find(va[31:12]);
        w0 = walks;
        req_vaddr_i = va;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (idx >= 0) begin
            exp_pa = {m_ppn[idx], va[11:0]};
            chk(resp_valid_o == 1'b1, req, "hit response next cycle", {31'd0, resp_valid_o}, 1);
            chk(resp_paddr_o == exp_pa, req, "hit address", resp_paddr_o, exp_pa);
            chk(resp_fault_o == 1'b0, req, "hit fault flag", {31'd0, resp_fault_o}, 0);
            chk(walks == w0 && !mem_req_valid_o, "R2", "no walk on hit", walks - w0, 0);
            return;
        end
        n = 0;
        while (!resp_valid_o && n < 200) begin
            if (mem_req_valid_o && req_ready_o)
                chk(0, "R6", "ready during walk", 1, 0);
            @(negedge clk);
            n++;
        end
        chk(!req_ready_o || resp_valid_o, "R6", "walk completes", {31'd0, resp_valid_o}, 1);
        chk(walks - w0 == 1, req, "one walk on miss", walks - w0, 1);
        if (pte_ok(va[31:12])) begin
            model_install(va[31:12]);
            exp_pa = {pte_ppn(va[31:12]), va[11:0]};
            chk(resp_fault_o == 1'b0 && resp_paddr_o == exp_pa, "R4", "refill address",
                resp_paddr_o, exp_pa);
            chk(cyc - resp_cyc == 2, "R4", "refill answer cycle", cyc - resp_cyc, 2);
        end else begin
            chk(resp_fault_o == 1'b1, "R5", "fault flag", {31'd0, resp_fault_o}, 1);
            chk(cyc - resp_cyc == 1, "R5", "fault answer cycle", cyc - resp_cyc, 1);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        #1;
        chk(req_ready_o == 1'b0, "R9", "ready low during flush", {31'd0, req_ready_o}, 0);
        @(negedge clk);
        flush_i = 1'b0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready_o && !resp_valid_o && !mem_req_valid_o, "R1", "reset outputs",
            {29'd0, req_ready_o, resp_valid_o, mem_req_valid_o}, 32'h4);

        // Empty after reset: first lookup walks
        lookup(32'h0001_0123, "R1");
        lookup(32'h0001_0ABC, "R2");
        lookup(32'h0001_0000, "R2");
        lookup(32'h0001_0FFF, "R2");

        // Invalid entry: faults, not installed
        lookup(32'h0000_3010, "R5");
        lookup(32'h0000_3020, "R5");

        // Fill every slot from empty, lowest slot first
        do_flush();
        lookup(32'h0001_0123, "R9");
        begin
            int v = 200;
            while (model_find(20'(v)) < 0 && m_valid[N-1] == 0) begin
                if (pte_ok(20'(v))) lookup({12'(v), 20'h00000} >> 0 | (v << 12), "R7");
                v++;
            end
        end
        for (int i = 0; i < N; i++) lookup({m_vpn[i], 12'h044}, "R7");

        // Full: round-robin victims with wrap-around
        for (int k = 0; k < N + 3; k++) lookup({20'(900 + 7 * k), 12'h321}, "R8");
        for (int k = 0; k < N + 3; k++) lookup({20'(900 + 7 * k), 12'h0F0}, "R8");

        // Random mix with changing table base
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 40 == 0) pt_root_i = {$urandom % 32'h0010_0000, 12'h000};
            if ($urandom % 60 == 0) do_flush();
            lookup({20'h00400 + 20'($urandom % 24), 12'($urandom)}, "R2");
        end

        do_flush();
        lookup(32'h0001_0555, "R9");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule